// File: doc/BRIEF.md
# Runtime-Configurable SPI Master Byte Engine

This block is an SPI master that sends and receives one 8-bit byte at a time over a serial clock, a master-out data line, a master-in data line and an active-low select. Clock polarity, clock phase and bit order come from three control inputs. The engine latches them when a transfer starts, so every transfer may use a different mode. A divider input sets the rate of the serial clock relative to the system clock.

To run a transfer, hold the controls and the divider steady and pulse `start_i` for one cycle with the byte on `tx_data_i`. The engine then pulls the select low and produces sixteen serial clock edges. On every edge it either drives the next outgoing bit or samples the incoming line, depending on the latched mode. After a final half period it releases the select, pulses `done_o` and shows the received byte on `rx_data_o`.

Top module: `spi_xfer_engine`

## Requirements
- R1: The engine changes MOSI only on setup edges and samples MISO only on the opposite, sampling edges, so MOSI stays unchanged from each sampling edge until the next setup edge.
- R2: When idle, SCK sits at the level of `cpol_i`: 0 if `cpol_i`=0, 1 if `cpol_i`=1. At the moment the select rises, SCK is back at the latched idle level.
- R3: With `cpha_i`=0, the engine samples on leading edges (edges 1,3,..,15 counted from 1) and sets up on trailing edges. With `cpha_i`=1, it sets up on leading edges and samples on trailing edges. A leading edge is one that leaves the idle level.
- R4: With `cpha_i`=0, the first outgoing bit is on MOSI in the same cycle the select falls. With `cpha_i`=1, the first bit is driven at the first SCK edge.
- R5: If `lsb_first_i`=0, transmit and receive go bit 7 first, bit 0 last. If `lsb_first_i`=1, they go bit 0 first.
- R6: Each transfer produces exactly 16 SCK edges, all while `ss_no` is low.
- R7: The first SCK edge comes `div_i`+1 system clocks after the select falls. Each later SCK edge comes `div_i`+1 clocks after the one before it. The select rises `div_i`+1 clocks after the last edge. `div_i` must be at least 1; a value of 0 is treated as 1.
- R8: A `start_i` pulse while `busy_o` is high is ignored. It does not change the transfer in progress and does not start another one.
- R9: `done_o` is high for exactly one system clock per transfer, in the cycle the select rises. From then on, `rx_data_o` holds the received byte, unchanged through the following transfer until that transfer's `done_o`.
- R10: `cpol_i`, `cpha_i`, `lsb_first_i` and `div_i` are latched at start. Changing them during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle transfer request |
| tx_data_i | input | 8 | Byte to transmit, taken at start |
| cpol_i | input | 1 | Idle level of SCK |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| lsb_first_i | input | 1 | 1: bit 0 first, 0: bit 7 first |
| div_i | input | 8 | Half period of SCK minus one, in system clocks |
| miso_i | input | 1 | Serial data from the slave |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| ss_no | output | 1 | Slave select, active low |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rx_data_o | output | 8 | Last received byte |

## Verification
The bench sweeps every polarity, phase and bit-order combination over several divider values and data patterns. A behavioural slave on the serial lines records MOSI at each sampling edge and drives MISO on each setup edge, so an engine that confuses leading and trailing edges gets bytes shifted by one bit. Sampling or setting up on the wrong edge, and a phase-0 first bit that appears late, both show up as corrupted bytes in one or both directions. The bench also times every SCK edge against the divider, counts the edges, and checks the SCK level when the select rises. In some transfers it fires a second start with different data and changes the mode inputs mid-transfer; an engine that reloads or follows the live inputs then returns the wrong bytes or a stretched or second done pulse.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } xfer_state_t;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
  } xfer_mode_t;
endpackage

// File: rtl/spi_xfer_tick.sv
module spi_xfer_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $past(en_i) && $stable(div_i) |-> cnt_q <= div_i);  // R7
endmodule

// File: rtl/spi_xfer_shifter.sv
module spi_xfer_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              lsb_first_i,
  input  logic              tx_shift_i,
  input  logic              rx_shift_i,
  input  logic              miso_i,
  output logic              tx_bit_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic [DATA_W-1:0] tx_sr_q, rx_sr_q;

  assign tx_bit_o  = lsb_first_i ? tx_sr_q[0] : tx_sr_q[DATA_W-1];
  assign rx_data_o = rx_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q <= '0;
    end else if (load_i) begin
      tx_sr_q <= load_data_i;
    end else if (tx_shift_i) begin
      if (lsb_first_i) tx_sr_q <= {1'b0, tx_sr_q[DATA_W-1:1]};
      else             tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sr_q <= '0;
    end else if (load_i) begin
      rx_sr_q <= '0;
    end else if (rx_shift_i) begin
      if (lsb_first_i) rx_sr_q <= {miso_i, rx_sr_q[DATA_W-1:1]};
      else             rx_sr_q <= {rx_sr_q[DATA_W-2:0], miso_i};
    end
  end

  AST_NO_DUAL_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_shift_i && rx_shift_i));  // R1
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              lsb_first_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              ss_no,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES + 1);

  xfer_state_t       state_q;
  xfer_mode_t        mode_q;
  logic [DIV_W-1:0]  div_q;
  logic [EW-1:0]     edge_q;
  logic              sck_q, ss_q, done_q;
  logic [DATA_W-1:0] rx_q;

  logic              accept, tick, leading, in_shift;
  logic              sample_edge, setup_edge, tx_bit;
  logic [DATA_W-1:0] rx_sr;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign in_shift = (state_q == ST_SHIFT);
  assign leading  = ~edge_q[0];
  // cpha=0: sample leading; cpha=1: sample trailing
  assign sample_edge = tick && in_shift && (leading ^ mode_q.cpha);
  // cpha=1 first leading edge drives bit 0, already on the shifter output
  assign setup_edge  = tick && in_shift && !(leading ^ mode_q.cpha)
                       && !(mode_q.cpha && edge_q == '0);

  spi_xfer_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q != ST_IDLE),
    .div_i  (div_q),
    .tick_o (tick)
  );

  spi_xfer_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .load_data_i (tx_data_i),
    .lsb_first_i (mode_q.lsb_first),
    .tx_shift_i  (setup_edge),
    .rx_shift_i  (sample_edge),
    .miso_i      (miso_i),
    .tx_bit_o    (tx_bit),
    .rx_data_o   (rx_sr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      div_q   <= DIV_W'(1);
      edge_q  <= '0;
      sck_q   <= 1'b0;
      ss_q    <= 1'b1;
      done_q  <= 1'b0;
      rx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          sck_q <= cpol_i;
          if (start_i) begin
            mode_q  <= '{cpol: cpol_i, cpha: cpha_i, lsb_first: lsb_first_i};
            div_q   <= (div_i == '0) ? DIV_W'(1) : div_i;
            edge_q  <= '0;
            ss_q    <= 1'b0;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sck_q  <= ~sck_q;
            edge_q <= edge_q + 1'b1;
            if (edge_q == EW'(EDGES - 1)) state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (tick) begin
            ss_q    <= 1'b1;
            done_q  <= 1'b1;
            rx_q    <= rx_sr;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sck_o     = sck_q;
  assign ss_no     = ss_q;
  assign mosi_o    = ss_q ? 1'b0 : tx_bit;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign rx_data_o = rx_q;

  AST_MOSI_HELD_AT_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_edge |=> $stable(mosi_o));  // R1
  AST_SS_RISE_AT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_no) |-> sck_o == mode_q.cpol);  // R2
  AST_EDGE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_q <= EW'(EDGES));  // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_shift && start_i |=> busy_o && !ss_no);  // R8
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R9
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mode_q) && $stable(div_q));  // R10
endmodule

// File: tb/tb_spi_xfer_engine.sv
`timescale 1ns/1ps
module tb_spi_xfer_engine;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       cpol_i = 1'b0, cpha_i = 1'b0, lsb_first_i = 1'b0;
  logic [7:0] div_i = 8'd1;
  logic       miso_i = 1'b0;
  logic       sck_o, mosi_o, ss_no, busy_o, done_o;
  logic [7:0] rx_data_o;

  int n_vec = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  spi_xfer_engine dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .tx_data_i(tx_data_i),
    .cpol_i(cpol_i), .cpha_i(cpha_i), .lsb_first_i(lsb_first_i), .div_i(div_i),
    .miso_i(miso_i), .sck_o(sck_o), .mosi_o(mosi_o), .ss_no(ss_no),
    .busy_o(busy_o), .done_o(done_o), .rx_data_o(rx_data_o)
  );

  // slave model state
  logic [7:0] s_tx, m_rx;
  logic       s_cpha, s_lsb;
  int         s_div, e_cnt, sb, rb, period_bad, first_bad;
  time        t_last;

  function automatic logic s_bit(int i);
    return s_lsb ? s_tx[i] : s_tx[7-i];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always begin
    @(negedge ss_no);
    e_cnt = 0; sb = 0; rb = 0; m_rx = '0;
    t_last = $time;
    #1;
    if (!s_cpha) begin
      if (mosi_o !== (s_lsb ? tx_data_i[0] : tx_data_i[7])) first_bad = 1;  // R4
      miso_i = s_bit(0);
      sb = 1;
    end
  end

  always @(sck_o) begin
    if (!ss_no) begin
      if ($time - t_last != time'((s_div + 1) * 10)) period_bad = 1;  // R7
      t_last = $time;
      if (((e_cnt % 2) == 0) ^ s_cpha) begin
        m_rx[s_lsb ? rb : 7 - rb] = mosi_o;
        rb++;
      end else begin
        if (sb < 8) miso_i = s_bit(sb);
        sb++;
      end
      e_cnt++;
    end
  end

  always @(posedge ss_no) begin
    if (rst_ni && $time - t_last != time'((s_div + 1) * 10)) period_bad = 1;  // R7
  end

  task automatic xfer(input bit pol, input bit pha, input bit lsb, input int dv,
                      input logic [7:0] tx, input logic [7:0] sl, input bit disturb);
    int cyc, dones;
    logic [7:0] prev_rx;
    @(negedge clk_i);
    cpol_i = pol; cpha_i = pha; lsb_first_i = lsb; div_i = 8'(dv); tx_data_i = tx;
    s_tx = sl; s_cpha = pha; s_lsb = lsb; s_div = dv;
    period_bad = 0; first_bad = 0;
    repeat (2) @(negedge clk_i);
    chk(sck_o == pol && ss_no, "R2", int'(sck_o), int'(pol));
    prev_rx = rx_data_o;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    tx_data_i = ~tx;
    chk(busy_o && !ss_no, "R6", int'(ss_no), 0);
    cyc = 0; dones = 0;
    while (!done_o && cyc < 4000) begin
      cyc++;
      if (disturb && cyc == 3 * dv + 2) begin
        start_i = 1'b1; cpol_i = ~pol; cpha_i = ~pha; lsb_first_i = ~lsb;
        div_i = 8'(dv + 3);
      end else begin
        start_i = 1'b0;
      end
      if (disturb && cyc == 6 * dv)
        chk(rx_data_o == prev_rx, "R9", int'(rx_data_o), int'(prev_rx));
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(done_o, "R7", cyc, 17 * (dv + 1));
    chk(ss_no && sck_o == pol, "R2", int'(sck_o), int'(pol));
    chk(rx_data_o == sl, disturb ? "R10" : "R3", int'(rx_data_o), int'(sl));
    chk(m_rx == tx, disturb ? "R8" : "R5", int'(m_rx), int'(tx));
    chk(e_cnt == 16, "R6", e_cnt, 16);
    chk(period_bad == 0, "R7", period_bad, 0);
    chk(first_bad == 0, "R4", first_bad, 0);
    @(negedge clk_i);
    dones = int'(done_o);
    chk(dones == 0 && !busy_o, "R9", dones, 0);
    repeat (3) @(negedge clk_i);
    chk(rx_data_o == sl && !busy_o, "R9", int'(rx_data_o), int'(sl));
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    s_tx = '0; s_cpha = 0; s_lsb = 0; s_div = 1; m_rx = '0;
    e_cnt = 0; sb = 0; rb = 0; period_bad = 0; first_bad = 0; t_last = 0;
    repeat (3) @(negedge clk_i);
    chk(ss_no && !sck_o && !busy_o && !done_o && rx_data_o == 8'h00 && !mosi_o,
        "R2", int'({ss_no, sck_o, busy_o, done_o}), 4'b1000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 3; d++) begin
        for (int p = 0; p < 4; p++) begin
          automatic int dv = (d == 0) ? 1 : (d == 1) ? 2 : 4;
          automatic logic [7:0] tx = 8'(p * 59 + m * 17 + 1);
          automatic logic [7:0] sl = 8'((p * 113) ^ (m * 29) ^ 8'hC6);
          xfer(m[2], m[1], m[0], dv, tx, sl, (p == 3));
        end
      end
    end
    xfer(1'b0, 1'b0, 1'b0, 1, 8'h80, 8'h01, 1'b0);  // R5 single-bit edge patterns
    xfer(1'b1, 1'b1, 1'b1, 1, 8'h01, 8'h80, 1'b0);  // R5
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule